// File: doc/BRIEF.md
# Plug-in card type classifier

This block sits on the host side of a memory-card slot. It works out what kind of card, if any, is inserted, and it decides whether each access to that card may proceed. Its input is a sensed two-bit detect code, which says whether the detect line is floating, pulled low or pulled high. The block waits until that code has held steady for a set number of cycles. A floating line means the slot is empty, and a low line means a read-only card. A high line starts an active probe over the byte-wide card bus. The probe saves the byte at a probe address. It writes a pattern there and reads it back. It then writes the complement and reads that back. Last, it puts the saved byte back. If both reads match, the card is a writable memory card. If either read fails, the card is an unrecognised device.

The classified state feeds a combinational permission decode. An empty slot grants nothing. A read-only card grants reads and refuses writes. A writable memory card grants everything. An unrecognised device looks like an empty slot to user-level requests, but machine-level requests still go through. Any change in the detect code drops the state back to empty and starts detection again.

Top module: `card_classifier`

## Requirements
- R1: State encoding is 00 empty, 01 read-only, 10 writable, 11 unknown. Detect code encoding is 00 floating, 01 low, 10 high, and 11 is treated like floating. A new detect code must hold steady for DEB_CYCLES clock cycles before it is classified, and the state reads empty until then.
- R2: A floating detect code (00 or 11) gives state empty. In that state acc_ok is 0 for every request, and no card write strobe is issued.
- R3: A low detect code gives state read-only. Read requests are granted, write requests are refused, and no card write strobe is issued.
- R4: A high detect code with a passing probe gives state writable, and every request is granted.
- R5: The probe writes PATTERN (default 8'hA5) and then its complement (8'h5A) to the probe address, reading each back after it is written. A mismatch on either read gives state unknown.
- R6: In state unknown, requests with acc_mach=0 are refused and requests with acc_mach=1 are granted.
- R7: card_we_n goes low only while the detect code is high and unchanged since the previous cycle. A write request is granted only while the detect code is high.
- R8: card_we_n and card_oe_n are active low and card_ce is active high, and the two enables are never low together. The top bit of card_addr carries the inverse of the logical address bit, so the default logical probe address 8'h05 appears on the port as 8'h85.
- R9: After a completed probe, the probe location holds the byte it held before the probe.
- R10: A change of the detect code makes the state read empty one cycle later, and classification starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_code | input | 2 | Sensed detect level: 00 floating, 01 low, 10 high |
| card_addr | output | AW | Card address, top bit inverted |
| card_wdata | output | DW | Card write data |
| card_rdata | input | DW | Card read data |
| card_ce | output | 1 | Card enable, active high |
| card_oe_n | output | 1 | Card output enable, active low |
| card_we_n | output | 1 | Card write enable, active low |
| card_state | output | 2 | Classified card state |
| acc_req | input | 1 | Access request present |
| acc_wr | input | 1 | Request is a write (1) or a read (0) |
| acc_mach | input | 1 | Request is machine level (1) or user level (0) |
| acc_ok | output | 1 | Request is permitted |

## Verification
The classifier is tried with six slot patterns. These are a floating line, the reserved code 11, a low line, a high line on a working memory, a high line on a card that ignores writes, and a high line on a card with one bit stuck at one. The last two separate a failure on the pattern read from a failure on the complement read. For each outcome, all four combinations of read or write and user or machine level are checked against the permission rules. The card write strobes are counted, which shows that empty and read-only slots are never written and that a writable card gets exactly three writes at the inverted-top-bit address. Directed cases cover the debounce window, a detect change from the writable state, and a glitch that interrupts a probe part way through.

// File: rtl/card_classifier.sv
module card_classifier #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int DEB_CYCLES = 16,
  parameter logic [AW-1:0] PROBE_ADDR = 'h05,
  parameter logic [DW-1:0] PATTERN = 'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    det_code,
  output logic [AW-1:0] card_addr,
  output logic [DW-1:0] card_wdata,
  input  logic [DW-1:0] card_rdata,
  output logic          card_ce,
  output logic          card_oe_n,
  output logic          card_we_n,
  output logic [1:0]    card_state,
  input  logic          acc_req,
  input  logic          acc_wr,
  input  logic          acc_mach,
  output logic          acc_ok
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [1:0] DET_LOW = 2'b01, DET_HIGH = 2'b10;
  localparam logic [1:0] ST_EMPTY = 2'b00, ST_ROM = 2'b01, ST_RAM = 2'b10, ST_UNK = 2'b11;

  typedef enum logic [2:0] {P_DEB, P_RD0, P_WPAT, P_RPAT, P_WINV, P_RINV, P_REST, P_DONE} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [1:0]    det_q;
  logic [DW-1:0] orig;
  logic          fail;
  logic [1:0]    state;

  wire changed = det_code != det_q;
  wire live    = !changed && det_code == DET_HIGH;
  wire is_rd   = phase == P_RD0 || phase == P_RPAT || phase == P_RINV;
  wire is_wr   = phase == P_WPAT || phase == P_WINV || phase == P_REST;

  assign card_ce    = live && (is_rd || is_wr);
  assign card_oe_n  = !(card_ce && is_rd);
  assign card_we_n  = !(card_ce && is_wr);
  assign card_addr  = {~PROBE_ADDR[AW-1], PROBE_ADDR[AW-2:0]};
  assign card_wdata = phase == P_WPAT ? PATTERN : phase == P_WINV ? ~PATTERN : orig;
  assign card_state = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_DEB;
      cnt   <= '0;
      det_q <= '0;
      orig  <= '0;
      fail  <= 1'b0;
      state <= ST_EMPTY;
    end else begin
      det_q <= det_code;
      if (changed) begin
        phase <= P_DEB;
        cnt   <= '0;
        state <= ST_EMPTY;
      end else begin
        case (phase)
          P_DEB: begin
            if (cnt == CW'(DEB_CYCLES - 1)) begin
              fail <= 1'b0;
              if (det_code == DET_HIGH) begin
                phase <= P_RD0;
              end else begin
                phase <= P_DONE;
                state <= det_code == DET_LOW ? ST_ROM : ST_EMPTY;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          P_RD0: begin
            orig  <= card_rdata;
            phase <= P_WPAT;
          end
          P_WPAT: phase <= P_RPAT;
          P_RPAT: begin
            if (card_rdata != PATTERN) fail <= 1'b1;
            phase <= P_WINV;
          end
          P_WINV: phase <= P_RINV;
          P_RINV: begin
            if (card_rdata != ~PATTERN) fail <= 1'b1;
            phase <= P_REST;
          end
          P_REST: begin
            state <= fail ? ST_UNK : ST_RAM;
            phase <= P_DONE;
          end
          default: phase <= P_DONE;
        endcase
      end
    end
  end

  logic grant;
  always_comb begin
    case (state)
      ST_ROM:  grant = !acc_wr;
      ST_RAM:  grant = 1'b1;
      ST_UNK:  grant = acc_mach;
      default: grant = 1'b0;
    endcase
  end

  assign acc_ok = acc_req && grant && (!acc_wr || det_code == DET_HIGH);
endmodule

// File: rtl/card_classifier_chk.sv
module card_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] det_code,
  input logic       card_ce,
  input logic       card_oe_n,
  input logic       card_we_n,
  input logic [1:0] card_state,
  input logic       acc_wr,
  input logic       acc_mach,
  input logic       acc_ok
);
  // R2
  empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_state == 2'b00 |-> !acc_ok);
  // R3
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'b01 && acc_wr) |-> !acc_ok);
  // R6
  unknown_user_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'b11 && !acc_mach) |-> !acc_ok);
  // R7
  write_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_we_n |-> (card_ce && det_code == 2'b10 && $stable(det_code)));
  // R8
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_we_n && !card_oe_n));
  // R10
  change_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_code != $past(det_code)) |=> card_state == 2'b00);
endmodule

bind card_classifier card_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det_code(det_code), .card_ce(card_ce),
  .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_state(card_state),
  .acc_wr(acc_wr), .acc_mach(acc_mach), .acc_ok(acc_ok)
);

// File: tb/card_classifier_tb.sv
module card_classifier_tb;
  localparam int DEB = 8;
  localparam logic [7:0] PROBE_PORT = 8'h85;
  localparam logic [7:0] ORIG = 8'h3C;
  // {det_code, card model mode, expected state}; mode 0 good, 1 ignores writes, 2 bit0 stuck at 1
  localparam logic [5:0] VEC [0:5] = '{
    {2'b00, 2'd0, 2'b00},
    {2'b11, 2'd0, 2'b00},
    {2'b01, 2'd0, 2'b01},
    {2'b10, 2'd0, 2'b10},
    {2'b10, 2'd1, 2'b11},
    {2'b10, 2'd2, 2'b11}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] det_code = 2'b00;
  logic [7:0] card_addr, card_wdata, card_rdata;
  logic card_ce, card_oe_n, card_we_n, acc_ok;
  logic [1:0] card_state;
  logic acc_req = 0, acc_wr = 0, acc_mach = 0;
  logic [1:0] mode = 0;
  logic clr = 0, preset = 0;
  logic [7:0] mem [0:255];
  int n_wr;
  logic [7:0] first_addr, first_data;
  int errors = 0, total = 0, cycles = 0;

  always #10 clk = ~clk;

  card_classifier #(.DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_code(det_code), .card_addr(card_addr),
    .card_wdata(card_wdata), .card_rdata(card_rdata), .card_ce(card_ce),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_state(card_state),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_mach(acc_mach), .acc_ok(acc_ok)
  );

  assign card_rdata = mode == 2'd2 ? (mem[card_addr] | 8'h01) : mem[card_addr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (clr) begin
      n_wr <= 0; first_addr <= 0; first_data <= 0;
    end else if (card_ce && !card_we_n) begin
      if (n_wr == 0) begin first_addr <= card_addr; first_data <= card_wdata; end
      n_wr <= n_wr + 1;
      if (mode != 2'd1) mem[card_addr] <= card_wdata;
    end
    if (preset) mem[PROBE_PORT] <= ORIG;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_ok(input logic [1:0] st, input logic wr, input logic mach, input logic [1:0] det);
    logic g;
    case (st)
      2'b01: g = !wr;
      2'b10: g = 1'b1;
      2'b11: g = mach;
      default: g = 1'b0;
    endcase
    return g && (!wr || det == 2'b10);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic perm_check(input logic [1:0] st);
    for (int k = 0; k < 4; k++) begin
      acc_req = 1; acc_wr = k[1]; acc_mach = k[0];
      #1;
      chk($sformatf("R2/R3/R4/R6 grant st=%0d wr=%0d mach=%0d", st, k[1], k[0]),
          acc_ok, exp_ok(st, k[1], k[0], det_code));
    end
    acc_req = 0; acc_wr = 1; acc_mach = 1;
    #1 chk("R2 no request no grant", acc_ok, 0);
    acc_wr = 0; acc_mach = 0;
  endtask

  task automatic settle_open;
    det_code = 2'b00;
    wait_cyc(DEB + 4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wait_cyc(3);
    chk("R1 reset state", card_state, 2'b00);
    chk("R8 reset ce", card_ce, 0);
    chk("R8 reset oe_n", card_oe_n, 1);
    chk("R8 reset we_n", card_we_n, 1);
    chk("R2 reset grant", acc_ok, 0);
    rst_n = 1;
    wait_cyc(2);

    foreach (VEC[v]) begin
      settle_open();
      mode = VEC[v][3:2];
      preset = 1; clr = 1;
      wait_cyc(1);
      preset = 0; clr = 0;
      det_code = VEC[v][5:4];
      wait_cyc(DEB + 12);
      chk($sformatf("R1/R2/R3/R4/R5 state vec %0d", v), card_state, VEC[v][1:0]);
      if (VEC[v][5:4] != 2'b10)
        chk($sformatf("R3/R7 no write strobes vec %0d", v), n_wr, 0);
      else
        chk($sformatf("R5 probe writes vec %0d", v), n_wr, 3);
      if (VEC[v][3:0] == {2'd0, 2'b10}) begin
        chk("R8 inverted top address bit", first_addr, PROBE_PORT);
        chk("R5 first write is pattern", first_data, 8'hA5);
        chk("R9 probe byte restored", mem[PROBE_PORT], ORIG);
      end
      perm_check(VEC[v][1:0]);
    end

    // R10: detect change from writable state
    settle_open();
    mode = 0;
    det_code = 2'b10;
    wait_cyc(DEB + 12);
    chk("R4 writable before change", card_state, 2'b10);
    det_code = 2'b01;
    wait_cyc(1);
    chk("R10 empty one cycle after change", card_state, 2'b00);
    acc_req = 1; #1;
    chk("R10 read refused after change", acc_ok, 0);
    acc_req = 0;
    wait_cyc(DEB + 4);
    chk("R10 reclassified as read-only", card_state, 2'b01);
    acc_req = 1; acc_wr = 1; #1;
    chk("R7 write refused with low detect", acc_ok, 0);
    acc_req = 0; acc_wr = 0;

    // R1: debounce window
    settle_open();
    det_code = 2'b01;
    wait_cyc(DEB - 1);
    chk("R1 still empty inside debounce", card_state, 2'b00);
    wait_cyc(4);
    chk("R1 classified after debounce", card_state, 2'b01);

    // R10: glitch during probe
    settle_open();
    det_code = 2'b10;
    wait_cyc(DEB + 3);
    det_code = 2'b00;
    wait_cyc(1);
    det_code = 2'b10;
    wait_cyc(1);
    chk("R10 empty after glitch mid-probe", card_state, 2'b00);
    wait_cyc(DEB + 12);
    chk("R10 probe restarts to writable", card_state, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule